// File: doc/BRIEF.md
# Prefix-Extended Immediate Compare Unit

This block is the compare-with-immediate slice of a processor that has 16-bit instruction words and a 24-bit datapath. It accepts at most one instruction word per clock, qualified by a valid strobe. A side input marks words that sit in a branch delay slot. The block also reads all eight 24-bit general registers as one flattened input vector.

Extension prefix words carry high-order immediate bits ahead of a compare. The block keeps the payloads of the last two such words. When a compare arrives, it builds an unsigned immediate of 7, 20 or 24 bits and subtracts it from the selected register. Only the carry (borrow) and zero flags are registered; nothing is written back to the register file. A compare in a delay slot takes its short immediate alone.

Every accepted compare also pulses a done strobe and exposes the assembled immediate for one cycle. A downstream stage uses these, and so does the test bench. Results appear one clock after the compare word is accepted.

Top module: `imm_cmp_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `flag_c`, `flag_z` and `cmp_done` are 0. No prefix is pending, so a first compare uses only its 7-bit field.
- R2: A compare word has bits 15:10 equal to 6'b011100, the register index in bits 9:7 and an immediate in bits 6:0. With no pending prefix, the immediate is those 7 bits zero-extended to 24 bits.
- R3: A prefix word has bits 15:13 equal to 3'b110 and a 13-bit payload in bits 12:0. With exactly one pending prefix, the immediate is {4'b0, payload, imm7}.
- R4: With two pending prefixes, the older payload's bits 3:0 become immediate bits 23:20 and the newer payload forms bits 19:7. Prefixes 0xF and 0x1FFF followed by imm7 0x7F give 0xFFFFFF.
- R5: When more than two prefixes arrive in a row, only the last two count: the older one supplies bits 23:20 and the newer one supplies bits 19:7.
- R6: After a compare, `flag_c` is 1 exactly when the unsigned register value is less than the immediate.
- R7: After a compare, `flag_z` is 1 exactly when register minus immediate is zero modulo 2^24. `flag_c` and `flag_z` are never both 1.
- R8: A compare with `delay_slot` high uses only its zero-extended 7-bit field and ignores pending prefixes. Those prefixes are discarded as well.
- R9: Any accepted word that is neither a prefix nor a compare discards pending prefixes. Cycles with `instr_valid` low leave pending prefixes in place.
- R10: Results are registered. One clock after a compare is accepted, `cmp_done` is 1 and `cmp_imm` holds its immediate. In every other cycle `cmp_done` is 0, and the flags keep their values in cycles that follow no compare.
- R11: The compare reads register number instr[9:7] from `rf_rdata`, where register k occupies bits 24k+23:24k, and never changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 16 | Instruction word |
| delay_slot | input | 1 | The presented word sits in a branch delay slot |
| rf_rdata | input | 192 | All eight 24-bit registers, register k at bits 24k+23:24k |
| flag_c | output | 1 | Carry flag: borrow of the last compare |
| flag_z | output | 1 | Zero flag: last compare found equality |
| cmp_done | output | 1 | One-cycle pulse after each accepted compare |
| cmp_imm | output | 24 | Immediate used by the compare just completed |

## Verification
The bench builds the block with its default values: a 24-bit datapath and a 3-bit register index. This gives a 4-bit top field above the 13-bit prefix payload and the 7-bit short field, so every assembly form is exercised, including the all-ones immediate. With eight registers, every index can be selected. Random streams mix prefixes, compares, other words, idle cycles and delay-slot marks, and often set the register equal to the expected immediate so that the zero and borrow boundaries are hit.

// File: rtl/imm_cmp_pkg.sv
package imm_cmp_pkg;

    localparam int INSTR_W    = 16;
    localparam int IMM7_W     = 7;
    localparam int REG_IDX_W  = 3;
    localparam int CMP_OPC_W  = 6;
    localparam int EXT_OPC_W  = 3;
    localparam int EXT_W      = 13;

    localparam logic [CMP_OPC_W-1:0] CMP_OPC = 6'b011100;
    localparam logic [EXT_OPC_W-1:0] EXT_OPC = 3'b110;

    // Number of prefix payloads kept at most
    localparam int PFX_DEPTH  = 2;

    typedef enum logic [1:0] {
        INS_NONE  = 2'd0,
        INS_EXT   = 2'd1,
        INS_CMP   = 2'd2,
        INS_OTHER = 2'd3
    } ins_kind_e;

endpackage

// File: rtl/imm_cmp_decode.sv
module imm_cmp_decode
    import imm_cmp_pkg::*;
(
    input  logic                 valid_i,
    input  logic [INSTR_W-1:0]   instr_i,
    output ins_kind_e            kind_o,
    output logic [REG_IDX_W-1:0] reg_idx_o,
    output logic [IMM7_W-1:0]    imm7_o,
    output logic [EXT_W-1:0]     ext_payload_o
);

    logic [CMP_OPC_W-1:0] cmp_field;
    logic [EXT_OPC_W-1:0] ext_field;

    always_comb begin
        cmp_field     = instr_i[INSTR_W-1 -: CMP_OPC_W];
        ext_field     = instr_i[INSTR_W-1 -: EXT_OPC_W];
        reg_idx_o     = instr_i[IMM7_W +: REG_IDX_W];
        imm7_o        = instr_i[IMM7_W-1:0];
        ext_payload_o = instr_i[EXT_W-1:0];

        if (!valid_i) begin
            kind_o = INS_NONE;
        end else if (ext_field == EXT_OPC) begin
            kind_o = INS_EXT;
        end else if (cmp_field == CMP_OPC) begin
            kind_o = INS_CMP;
        end else begin
            kind_o = INS_OTHER;
        end
    end

endmodule

// File: rtl/imm_cmp_prefix.sv
module imm_cmp_prefix
    import imm_cmp_pkg::*;
#(
    parameter int DATA_W = 24
)(
    input  logic              clk,
    input  logic              rst_n,
    input  ins_kind_e         kind_i,
    input  logic              delay_slot_i,
    input  logic [EXT_W-1:0]  ext_payload_i,
    input  logic [IMM7_W-1:0] imm7_i,
    output logic [DATA_W-1:0] imm_o
);

    localparam int HI_W  = DATA_W - EXT_W - IMM7_W;
    localparam int CNT_W = $clog2(PFX_DEPTH + 1);
    localparam int MID_W = EXT_W + IMM7_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [HI_W-1:0]  hi;
        logic [EXT_W-1:0] mid;
    } pfx_state_t;

    pfx_state_t st_d, st_q;

    // Next-state: shift payloads on a prefix, clear on any other consumed word
    always_comb begin
        st_d = st_q;
        unique case (kind_i)
            INS_EXT: begin
                st_d.hi  = st_q.mid[HI_W-1:0];
                st_d.mid = ext_payload_i;
                if (st_q.cnt < CNT_W'(PFX_DEPTH)) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            INS_CMP, INS_OTHER: begin
                st_d = '0;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    // Immediate assembly for the word presented this cycle
    always_comb begin
        imm_o = '0;
        if (delay_slot_i || st_q.cnt == '0) begin
            imm_o = {{(DATA_W-IMM7_W){1'b0}}, imm7_i};
        end else if (st_q.cnt == CNT_W'(1)) begin
            imm_o = {{(DATA_W-MID_W){1'b0}}, st_q.mid, imm7_i};
        end else begin
            imm_o = {st_q.hi, st_q.mid, imm7_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/imm_cmp_alu.sv
module imm_cmp_alu #(
    parameter int DATA_W = 24
)(
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    output logic              borrow_o,
    output logic              zero_o
);

    logic [DATA_W:0] diff;

    always_comb begin
        diff     = {1'b0, lhs_i} - {1'b0, rhs_i};
        borrow_o = diff[DATA_W];
        zero_o   = (diff[DATA_W-1:0] == '0);
    end

endmodule

// File: rtl/imm_cmp_unit.sv
module imm_cmp_unit
    import imm_cmp_pkg::*;
#(
    parameter int DATA_W = 24
)(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                instr_valid,
    input  logic [INSTR_W-1:0]                  instr,
    input  logic                                delay_slot,
    input  logic [(2**REG_IDX_W)*DATA_W-1:0]    rf_rdata,
    output logic                                flag_c,
    output logic                                flag_z,
    output logic                                cmp_done,
    output logic [DATA_W-1:0]                   cmp_imm
);

    localparam int NREG = 2 ** REG_IDX_W;

    typedef struct packed {
        logic              c;
        logic              z;
        logic              done;
        logic [DATA_W-1:0] imm;
    } res_state_t;

    ins_kind_e            kind;
    logic [REG_IDX_W-1:0] reg_idx;
    logic [IMM7_W-1:0]    imm7;
    logic [EXT_W-1:0]     ext_payload;
    logic [DATA_W-1:0]    imm_full;
    logic [DATA_W-1:0]    reg_val;
    logic                 borrow;
    logic                 zero;
    logic [DATA_W-1:0]    rf_arr [NREG];

    res_state_t res_d, res_q;

    imm_cmp_decode u_decode (
        .valid_i       (instr_valid),
        .instr_i       (instr),
        .kind_o        (kind),
        .reg_idx_o     (reg_idx),
        .imm7_o        (imm7),
        .ext_payload_o (ext_payload)
    );

    imm_cmp_prefix #(.DATA_W(DATA_W)) u_prefix (
        .clk           (clk),
        .rst_n         (rst_n),
        .kind_i        (kind),
        .delay_slot_i  (delay_slot),
        .ext_payload_i (ext_payload),
        .imm7_i        (imm7),
        .imm_o         (imm_full)
    );

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_rf
            assign rf_arr[g] = rf_rdata[g*DATA_W +: DATA_W];
        end
    endgenerate

    assign reg_val = rf_arr[reg_idx];

    imm_cmp_alu #(.DATA_W(DATA_W)) u_alu (
        .lhs_i    (reg_val),
        .rhs_i    (imm_full),
        .borrow_o (borrow),
        .zero_o   (zero)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        if (kind == INS_CMP) begin
            res_d.c    = borrow;
            res_d.z    = zero;
            res_d.done = 1'b1;
            res_d.imm  = imm_full;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign flag_c   = res_q.c;
    assign flag_z   = res_q.z;
    assign cmp_done = res_q.done;
    assign cmp_imm  = res_q.imm;

endmodule

// File: rtl/imm_cmp_unit_chk.sv
module imm_cmp_unit_chk #(
    parameter int DATA_W = 24,
    parameter int NREG   = 8
)(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   instr_valid,
    input logic [5:0]             opc,
    input logic [2:0]             idx,
    input logic                   delay_slot,
    input logic [NREG*DATA_W-1:0] rf_rdata,
    input logic                   flag_c,
    input logic                   flag_z,
    input logic                   cmp_done,
    input logic [DATA_W-1:0]      cmp_imm
);

    logic              is_cmp;
    logic [DATA_W-1:0] sel_now;
    logic [DATA_W-1:0] sel_prev;

    assign is_cmp  = instr_valid && (opc == 6'b011100);
    assign sel_now = rf_rdata[idx*DATA_W +: DATA_W];

    always_ff @(posedge clk) begin
        sel_prev <= sel_now;
    end

    // R10: done strobe follows accepted compares by one clock
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> cmp_done);
    assert_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cmp |=> !cmp_done);
    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cmp |=> $stable({flag_c, flag_z}));
    // R7: borrow and equality are exclusive
    assert_cz_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_c && flag_z));
    // R8: delay-slot compare sees only the short field
    assert_delay_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmp && delay_slot) |=> (cmp_imm < DATA_W'(128)));
    // R6: borrow matches unsigned ordering of register and immediate
    assert_borrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_done |-> (flag_c == (sel_prev < cmp_imm)));
    // R7: zero matches equality
    assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_done |-> (flag_z == (sel_prev == cmp_imm)));

endmodule

bind imm_cmp_unit imm_cmp_unit_chk #(.DATA_W(DATA_W), .NREG(2 ** imm_cmp_pkg::REG_IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .opc         (instr[15:10]),
    .idx         (instr[9:7]),
    .delay_slot  (delay_slot),
    .rf_rdata    (rf_rdata),
    .flag_c      (flag_c),
    .flag_z      (flag_z),
    .cmp_done    (cmp_done),
    .cmp_imm     (cmp_imm)
);

// File: tb/imm_cmp_unit_tb.sv
module imm_cmp_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 24;
    localparam int NREG       = 8;

    logic                   clk;
    logic                   rst_n;
    logic                   instr_valid;
    logic [15:0]            instr;
    logic                   delay_slot;
    logic [NREG*DATA_W-1:0] rf_rdata;
    logic                   flag_c;
    logic                   flag_z;
    logic                   cmp_done;
    logic [DATA_W-1:0]      cmp_imm;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model
    int          m_cnt = 0;
    logic [3:0]  m_hi  = '0;
    logic [12:0] m_mid = '0;
    logic        m_c   = 1'b0;
    logic        m_z   = 1'b0;

    imm_cmp_unit #(.DATA_W(DATA_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .delay_slot  (delay_slot),
        .rf_rdata    (rf_rdata),
        .flag_c      (flag_c),
        .flag_z      (flag_z),
        .cmp_done    (cmp_done),
        .cmp_imm     (cmp_imm)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mk_ext(input logic [12:0] p);
        return {3'b110, p};
    endfunction

    function automatic logic [15:0] mk_cmp(input logic [2:0] r, input logic [6:0] i7);
        return {6'b011100, r, i7};
    endfunction

    function automatic logic [DATA_W-1:0] exp_imm(input logic [6:0] i7, input logic ds);
        if (ds || m_cnt == 0) return {17'd0, i7};
        if (m_cnt == 1)       return {4'd0, m_mid, i7};
        return {m_hi, m_mid, i7};
    endfunction

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_reg(input int r, input logic [DATA_W-1:0] v);
        rf_rdata[r*DATA_W +: DATA_W] = v;
    endtask

    // Drive one word at a negedge, check results after the next posedge.
    task automatic step(input logic v, input logic [15:0] w, input logic ds, input string tag);
        logic [DATA_W-1:0] e_imm;
        logic [DATA_W-1:0] rv;
        bit is_ext, is_cmp;
        is_ext = v && (w[15:13] == 3'b110);
        is_cmp = v && !is_ext && (w[15:10] == 6'b011100);
        instr_valid = v;
        instr       = w;
        delay_slot  = ds;
        e_imm = exp_imm(w[6:0], ds);
        rv    = rf_rdata[w[9:7]*DATA_W +: DATA_W];
        if (is_cmp) begin
            m_c = rv < e_imm;
            m_z = rv == e_imm;
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk({"R10 done ", tag}, {23'd0, cmp_done}, {23'd0, is_cmp});
        chk({"R6 carry ", tag}, {23'd0, flag_c}, {23'd0, m_c});
        chk({"R7 zero ", tag}, {23'd0, flag_z}, {23'd0, m_z});
        if (is_cmp) chk({"imm ", tag}, cmp_imm, e_imm);
        if (is_ext) begin
            m_hi  = m_mid[3:0];
            m_mid = w[12:0];
            if (m_cnt < 2) m_cnt++;
        end else if (v) begin
            m_cnt = 0; m_hi = '0; m_mid = '0;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; instr_valid = 1'b0; instr = '0; delay_slot = 1'b0;
        rf_rdata = '0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R1 reset flags", {22'd0, flag_c, flag_z}, 24'd0);
        chk("R1 reset done", {23'd0, cmp_done}, 24'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R7: first compare after reset, equal operands
        set_reg(0, 24'h00007F);
        step(1'b1, mk_cmp(3'd0, 7'h7F), 1'b0, "R1 R2 equal");
        // R4: all-ones immediate from two prefixes
        set_reg(1, 24'hFFFFFE);
        step(1'b1, mk_ext(13'h000F), 1'b0, "R4 p1");
        step(1'b1, mk_ext(13'h1FFF), 1'b0, "R4 p2");
        step(1'b1, mk_cmp(3'd1, 7'h7F), 1'b0, "R4 ffffff");
        chk("R4 all ones", cmp_imm, 24'hFFFFFF);
        // R3: single prefix
        set_reg(2, 24'h055E05);
        step(1'b1, mk_ext(13'h0ABC), 1'b0, "R3 p");
        step(1'b1, mk_cmp(3'd2, 7'h05), 1'b0, "R3 cmp");
        chk("R3 twenty bit", cmp_imm, 24'h055E05);
        // R5: three prefixes, oldest dropped
        step(1'b1, mk_ext(13'h0003), 1'b0, "R5 p1");
        step(1'b1, mk_ext(13'h0005), 1'b0, "R5 p2");
        step(1'b1, mk_ext(13'h1001), 1'b0, "R5 p3");
        step(1'b1, mk_cmp(3'd3, 7'h11), 1'b0, "R5 cmp");
        chk("R5 last two", cmp_imm, {4'h5, 13'h1001, 7'h11});
        // R8: delay slot ignores and discards prefix
        step(1'b1, mk_ext(13'h1234), 1'b0, "R8 p");
        step(1'b1, mk_cmp(3'd4, 7'h22), 1'b1, "R8 ds");
        chk("R8 short only", cmp_imm, 24'h000022);
        step(1'b1, mk_cmp(3'd4, 7'h23), 1'b0, "R8 after");
        chk("R8 discarded", cmp_imm, 24'h000023);
        // R9: other word clears, idle keeps
        step(1'b1, mk_ext(13'h0777), 1'b0, "R9 p");
        step(1'b1, 16'h0000, 1'b0, "R9 other");
        step(1'b1, mk_cmp(3'd5, 7'h01), 1'b0, "R9 cleared");
        chk("R9 cleared", cmp_imm, 24'h000001);
        step(1'b1, mk_ext(13'h0777), 1'b0, "R9 p2");
        step(1'b0, mk_cmp(3'd5, 7'h02), 1'b0, "R9 idle");
        step(1'b0, 16'h0000, 1'b0, "R9 idle2");
        step(1'b1, mk_cmp(3'd5, 7'h03), 1'b0, "R9 kept");
        chk("R9 kept", cmp_imm, {4'h0, 13'h0777, 7'h03});
        // R11: every register index, distinct values
        for (int r = 0; r < NREG; r++) set_reg(r, DATA_W'(r * 16));
        for (int r = 0; r < NREG; r++) begin
            step(1'b1, mk_cmp(3'(r), 7'(r * 16)), 1'b0, "R11 index");
            chk("R11 zero on own reg", {23'd0, flag_z}, 24'd1);
        end

        // Constrained random stream
        for (int n = 0; n < 4000; n++) begin
            int sel;
            logic [15:0] w;
            logic ds;
            for (int r = 0; r < NREG; r++) set_reg(r, DATA_W'($urandom));
            sel = $urandom_range(0, 9);
            ds  = ($urandom_range(0, 5) == 0);
            if (sel < 3) begin
                w = mk_ext(13'($urandom));
            end else if (sel < 8) begin
                w = mk_cmp(3'($urandom), 7'($urandom));
                if ($urandom_range(0, 3) == 0) set_reg(w[9:7], exp_imm(w[6:0], ds));
                else if ($urandom_range(0, 3) == 0) set_reg(w[9:7], exp_imm(w[6:0], ds) - 1);
            end else begin
                w = 16'($urandom);
                if (w[15:13] == 3'b110 || w[15:10] == 6'b011100) w[15] = ~w[15];
            end
            step(sel != 9, w, ds, "rand R2 R3 R4 R8");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule